// File: doc/BRIEF.md
# Quad-channel serial DAC write sequencer

This block sits on the host side of a four-channel, 12-bit serial digital-to-analog converter. A request carries a 2-bit channel number and a 12-bit output code. The block packs them into a 16-bit word and shifts it out on chip-select, serial clock and serial data. It then pulses a low-active load strobe so the addressed channel register takes the new code. A separate one-cycle command drives the converter's asynchronous reset line low. Before that, it sets the reset-select level, which chooses mid-scale or zero-scale.

Every interface minimum is given in nanoseconds as a parameter, together with the system clock period. The block turns each one into a whole number of system cycles, so one piece of RTL fits any clock rate. Requests use a ready/valid handshake. The block raises `busy` while a sequence runs and gives a single-cycle `done` when the sequence ends.

Top module: `qdac_wr_seq`

## Requirements
- R1: The serial word is sent most significant bit first, in this order: channel bit 1, channel bit 0, two pad bits driven as 0, then code bits 11 down to 0. The bit is read on each rising edge of `dac_sclk` while `dac_cs_n` is low.
- R2: `dac_sdi` changes only while `dac_sclk` is low. It does not change for at least ceil(25/P) cycles before a rising clock edge, nor for ceil(20/P) cycles after one. P is the system clock period in ns, and every derived count is at least 1.
- R3: Inside a frame, each clock high phase lasts exactly max(ceil(30/P), ceil(20/P)) cycles. Each low phase lasts exactly max(ceil(50/P), ceil(25/P)) cycles. The first low phase instead lasts the larger of that value, ceil(55/P) and ceil(40/P).
- R4: `dac_cs_n` falls together with the first clock low phase, at least ceil(55/P) cycles before the first rising edge. It rises only while `dac_sclk` is high, after exactly 16 rising edges, at least ceil(15/P) cycles after the last rising edge.
- R5: `dac_load_n` stays high while `dac_cs_n` is low, and for at least ceil(40/P) cycles before the first rising edge. It falls only with `dac_cs_n` high, at least ceil(15/P) cycles after the last rising edge. It stays low for exactly ceil(45/P) cycles.
- R6: A reset command captures `rst_sel_in` onto `dac_rst_sel` at least ceil(25/P) cycles before `dac_rst_n` falls. `dac_rst_n` then stays low for exactly ceil(70/P) cycles. `dac_rst_sel` does not change while `dac_rst_n` is low.
- R7: `done` is high for exactly one cycle. It appears in the first cycle in which `dac_load_n` or `dac_rst_n` is back high after its pulse.
- R8: A request is accepted only when `req_ready` is high. `req_ready` is never high while `busy` is high. A request held valid during a frame is not sent.
- R9: A reset command that arrives during a frame does not disturb that frame. It runs after the frame's `done`, with the select level captured at command time. While it is pending, `req_ready` stays low.
- R10: After `rst_n`, the outputs are `dac_cs_n`, `dac_sclk`, `dac_load_n` and `dac_rst_n` high, `busy` and `done` low, `req_ready` high and `dac_rst_sel` low. Between frames, `dac_sclk` and `dac_cs_n` idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can take a write request |
| req_chan | input | ADDR_W | Channel number of the request |
| req_code | input | CODE_W | Output code of the request |
| rst_cmd | input | 1 | One-cycle command to reset the converter |
| rst_sel_in | input | 1 | Reset level to apply (1 mid-scale, 0 zero-scale) |
| busy | output | 1 | A frame or reset sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| dac_cs_n | output | 1 | Converter chip-select, active low |
| dac_sclk | output | 1 | Converter serial clock, idles high |
| dac_sdi | output | 1 | Converter serial data |
| dac_load_n | output | 1 | Converter register load strobe, active low |
| dac_rst_n | output | 1 | Converter asynchronous reset, active low |
| dac_rst_sel | output | 1 | Converter reset-level select |

## Verification
The hardest case to reach is a reset command that lands in the middle of a frame. A converter reset must then wait until the frame has finished, and its select level must survive until then. The bench starts a write and issues the command partway through the shift. It confirms that no reset pulse appears until the frame's `done`, that `req_ready` is held low at that point, and that the reset with the stored level follows. A second hard case is a request held valid throughout a running frame. The bench checks that no second load strobe follows.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOW    = 3'd1,
      ST_HIGH   = 3'd2,
      ST_LOAD   = 3'd3,
      ST_RSETUP = 3'd4,
      ST_RPULSE = 3'd5
   } seq_state_t;

   // whole cycles covering t_ns at a period of per_ns, never below one
   function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned per_ns);
      int unsigned c;
      c = (t_ns + per_ns - 1) / per_ns;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/qdac_tmr.sv
module qdac_tmr #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/qdac_shreg.sv
module qdac_shreg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   output logic         msb
);
   logic [W-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sr_q <= '0;
      else if (load)
         sr_q <= din;
      else if (shift)
         sr_q <= {sr_q[W-2:0], 1'b0};
   end

   assign msb = sr_q[W-1];
endmodule

// File: rtl/qdac_wr_seq.sv
module qdac_wr_seq
   import qdac_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 8,
   parameter int unsigned ADDR_W        = 2,
   parameter int unsigned PAD_W         = 2,
   parameter int unsigned CODE_W        = 12,
   parameter int unsigned T_DS_NS       = 25,
   parameter int unsigned T_DH_NS       = 20,
   parameter int unsigned T_CH_NS       = 30,
   parameter int unsigned T_CL_NS       = 50,
   parameter int unsigned T_CSS_NS      = 55,
   parameter int unsigned T_CSH_NS      = 15,
   parameter int unsigned T_LD1_NS      = 40,
   parameter int unsigned T_LD2_NS      = 15,
   parameter int unsigned T_LDW_NS      = 45,
   parameter int unsigned T_RSTW_NS     = 70,
   parameter int unsigned T_RSS_NS      = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_chan,
   input  logic [CODE_W-1:0] req_code,
   input  logic              rst_cmd,
   input  logic              rst_sel_in,
   output logic              busy,
   output logic              done,
   output logic              dac_cs_n,
   output logic              dac_sclk,
   output logic              dac_sdi,
   output logic              dac_load_n,
   output logic              dac_rst_n,
   output logic              dac_rst_sel
);
   localparam int unsigned FRAME_W   = ADDR_W + PAD_W + CODE_W;
   localparam int unsigned BW        = $clog2(FRAME_W);
   localparam int unsigned BIT_LOW   = umax(ns2cyc(T_CL_NS, CLK_PERIOD_NS), ns2cyc(T_DS_NS, CLK_PERIOD_NS));
   localparam int unsigned FIRST_LOW = umax(BIT_LOW, umax(ns2cyc(T_CSS_NS, CLK_PERIOD_NS),
                                                          ns2cyc(T_LD1_NS, CLK_PERIOD_NS)));
   localparam int unsigned BIT_HIGH  = umax(ns2cyc(T_CH_NS, CLK_PERIOD_NS), ns2cyc(T_DH_NS, CLK_PERIOD_NS));
   localparam int unsigned LAST_HIGH = umax(BIT_HIGH, umax(ns2cyc(T_CSH_NS, CLK_PERIOD_NS),
                                                           ns2cyc(T_LD2_NS, CLK_PERIOD_NS)));
   localparam int unsigned LOAD_LOW  = ns2cyc(T_LDW_NS, CLK_PERIOD_NS);
   localparam int unsigned RS_SETUP  = ns2cyc(T_RSS_NS, CLK_PERIOD_NS);
   localparam int unsigned RS_LOW    = ns2cyc(T_RSTW_NS, CLK_PERIOD_NS);
   localparam int unsigned DUR_MAX   = umax(umax(FIRST_LOW, LAST_HIGH), umax(LOAD_LOW, umax(RS_SETUP, RS_LOW)));
   localparam int unsigned TW        = (DUR_MAX < 2) ? 1 : $clog2(DUR_MAX);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_W - 1);

   // elaboration-time parameter checks
   if (CLK_PERIOD_NS == 0) begin : g_bad_period
      $error("CLK_PERIOD_NS must be non-zero");
   end
   if (ADDR_W < 1 || CODE_W < 1) begin : g_bad_width
      $error("ADDR_W and CODE_W must be at least 1");
   end
   if (FRAME_W < 2) begin : g_bad_frame
      $error("frame must hold at least two bits");
   end

   // word assembly: pad bits present only when PAD_W is non-zero
   logic [FRAME_W-1:0] frame_w;
   if (PAD_W > 0) begin : g_pad
      assign frame_w = {req_chan, {PAD_W{1'b0}}, req_code};
   end else begin : g_nopad
      assign frame_w = {req_chan, req_code};
   end

   seq_state_t    state_q, nstate;
   logic [BW-1:0] bit_q;
   logic          tmr_exp, tmr_load;
   logic [TW-1:0] tmr_val;
   int unsigned   dur;
   logic          accept, shift, take_rst, end_seq;
   logic          rst_pend_q, pend_sel_q;
   logic          cs_n_q, sclk_q, load_n_q, rstn_q, rsel_q, done_q;

   always_comb begin
      nstate = state_q;
      unique case (state_q)
         ST_IDLE:   if (rst_pend_q || rst_cmd) nstate = ST_RSETUP;
                    else if (req_valid)       nstate = ST_LOW;
         ST_LOW:    if (tmr_exp) nstate = ST_HIGH;
         ST_HIGH:   if (tmr_exp) nstate = (bit_q == LAST_BIT) ? ST_LOAD : ST_LOW;
         ST_LOAD:   if (tmr_exp) nstate = ST_IDLE;
         ST_RSETUP: if (tmr_exp) nstate = ST_RPULSE;
         ST_RPULSE: if (tmr_exp) nstate = ST_IDLE;
         default:   nstate = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (nstate)
         ST_LOW:    dur = (state_q == ST_IDLE) ? FIRST_LOW : BIT_LOW;
         ST_HIGH:   dur = (bit_q == LAST_BIT) ? LAST_HIGH : BIT_HIGH;
         ST_LOAD:   dur = LOAD_LOW;
         ST_RSETUP: dur = RS_SETUP;
         ST_RPULSE: dur = RS_LOW;
         default:   dur = 1;
      endcase
      tmr_val = TW'(dur - 1);
   end

   assign tmr_load = (nstate != state_q);
   assign accept   = (state_q == ST_IDLE) && (nstate == ST_LOW);
   assign shift    = (state_q == ST_HIGH) && (nstate == ST_LOW);
   assign take_rst = (state_q == ST_IDLE) && (nstate == ST_RSETUP);
   assign end_seq  = (state_q != ST_IDLE) && (nstate == ST_IDLE);

   qdac_tmr #(.W(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
   );

   qdac_shreg #(.W(FRAME_W)) u_sr (
      .clk(clk), .rst_n(rst_n), .load(accept), .din(frame_w), .shift(shift), .msb(dac_sdi)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bit_q      <= '0;
         rst_pend_q <= 1'b0;
         pend_sel_q <= 1'b0;
         cs_n_q     <= 1'b1;
         sclk_q     <= 1'b1;
         load_n_q   <= 1'b1;
         rstn_q     <= 1'b1;
         rsel_q     <= 1'b0;
         done_q     <= 1'b0;
      end else begin
         state_q <= nstate;
         if (accept)     bit_q <= '0;
         else if (shift) bit_q <= bit_q + 1'b1;
         if (take_rst)   rsel_q <= rst_pend_q ? pend_sel_q : rst_sel_in;
         if (rst_cmd && !(state_q == ST_IDLE && !rst_pend_q)) begin
            rst_pend_q <= 1'b1;
            pend_sel_q <= rst_sel_in;
         end else if (take_rst) begin
            rst_pend_q <= 1'b0;
         end
         cs_n_q   <= !(nstate == ST_LOW || nstate == ST_HIGH);
         sclk_q   <= (nstate != ST_LOW);
         load_n_q <= (nstate != ST_LOAD);
         rstn_q   <= (nstate != ST_RPULSE);
         done_q   <= end_seq;
      end
   end

   assign req_ready   = (state_q == ST_IDLE) && !rst_pend_q && !rst_cmd;
   assign busy        = (state_q != ST_IDLE);
   assign done        = done_q;
   assign dac_cs_n    = cs_n_q;
   assign dac_sclk    = sclk_q;
   assign dac_load_n  = load_n_q;
   assign dac_rst_n   = rstn_q;
   assign dac_rst_sel = rsel_q;
endmodule

// File: rtl/qdac_wr_seq_chk.sv
module qdac_wr_seq_chk
   import qdac_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_NS = 8,
   parameter int unsigned T_CL_NS       = 50,
   parameter int unsigned T_DS_NS       = 25,
   parameter int unsigned T_RSTW_NS     = 70
) (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic busy,
   input logic done,
   input logic dac_cs_n,
   input logic dac_sclk,
   input logic dac_load_n,
   input logic dac_rst_n,
   input logic dac_rst_sel
);
   localparam int unsigned LOW_MIN = umax(ns2cyc(T_CL_NS, CLK_PERIOD_NS), ns2cyc(T_DS_NS, CLK_PERIOD_NS));
   localparam int unsigned RST_MIN = ns2cyc(T_RSTW_NS, CLK_PERIOD_NS);

   logic [15:0] lo_cnt, rl_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         rl_cnt <= '0;
      end else begin
         lo_cnt <= dac_sclk  ? '0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1);
         rl_cnt <= dac_rst_n ? '0 : ((rl_cnt == 16'hFFFF) ? rl_cnt : rl_cnt + 1'b1);
      end
   end

   // R3
   sclk_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_sclk) |-> lo_cnt >= LOW_MIN);
   // R10
   idle_sclk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_cs_n |-> dac_sclk);
   // R4
   cs_rise_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_cs_n) |-> dac_sclk);
   // R5
   load_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_load_n |-> dac_cs_n);
   // R6
   rst_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_rst_n |-> $stable(dac_rst_sel));
   // R6
   rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_rst_n) |-> rl_cnt >= RST_MIN);
   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R7
   done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> dac_load_n && dac_rst_n);
   // R8
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !busy);
endmodule

bind qdac_wr_seq qdac_wr_seq_chk #(
   .CLK_PERIOD_NS(CLK_PERIOD_NS), .T_CL_NS(T_CL_NS), .T_DS_NS(T_DS_NS), .T_RSTW_NS(T_RSTW_NS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy), .done(done),
   .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_load_n(dac_load_n),
   .dac_rst_n(dac_rst_n), .dac_rst_sel(dac_rst_sel)
);

// File: tb/qdac_wr_seq_tb.sv
`timescale 1ns/1ps
module qdac_wr_seq_tb;
   localparam int PER = 8;

   function automatic int cyc(input int t);
      int c;
      c = (t + PER - 1) / PER;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int DS = cyc(25), DH = cyc(20), CH = cyc(30), CL = cyc(50);
   localparam int CSS = cyc(55), CSH = cyc(15), LD1 = cyc(40), LD2 = cyc(15);
   localparam int LDW = cyc(45), RSTW = cyc(70), RSS = cyc(25);
   localparam int E_BLOW  = mx(CL, DS);
   localparam int E_FLOW  = mx(E_BLOW, mx(CSS, LD1));
   localparam int E_BHIGH = mx(CH, DH);
   localparam int E_LHIGH = mx(E_BHIGH, mx(CSH, LD2));

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, rst_cmd = 1'b0, rst_sel_in = 1'b0;
   logic [1:0]  req_chan = '0;
   logic [11:0] req_code = '0;
   logic req_ready, busy, done, dac_cs_n, dac_sclk, dac_sdi, dac_load_n, dac_rst_n, dac_rst_sel;

   always #4 clk = ~clk;

   qdac_wr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_chan(req_chan), .req_code(req_code), .rst_cmd(rst_cmd), .rst_sel_in(rst_sel_in),
      .busy(busy), .done(done), .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdi(dac_sdi),
      .dac_load_n(dac_load_n), .dac_rst_n(dac_rst_n), .dac_rst_sel(dac_rst_sel)
   );

   int checks = 0, errors = 0;
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // port monitor, sampled on the falling edge
   int cnt = 1000;
   int t_rise = 0, t_fall = 0, t_csf = 0, t_sdi = 0, t_ldr = 0, t_ldf = 0, t_sel = 0, t_rsf = 0;
   int nbits = 0, n_frames = 0, n_resets = 0;
   logic [15:0] cap = '0, got_frame = '0;
   logic last_rsel = 1'b0;
   logic p_cs = 1, p_sclk = 1, p_sdi = 0, p_ld = 1, p_rn = 1, p_rsel = 0, p_done = 0;
   bit mon_on = 0;

   always @(negedge clk) begin
      cnt++;
      if (mon_on) begin
         if (dac_sdi != p_sdi) begin
            if (!dac_cs_n && !p_cs) begin
               chk(!dac_sclk && (cnt - t_rise >= DH), "R2 data hold / change while clock low", cnt - t_rise, DH);
            end
            t_sdi = cnt;
         end
         if (!dac_cs_n && p_cs) begin
            t_csf = cnt; nbits = 0; cap = '0;
         end
         if (!dac_sclk && p_sclk) begin
            if (!p_cs) chk(cnt - t_rise == E_BHIGH, "R3 high phase", cnt - t_rise, E_BHIGH);
            t_fall = cnt;
         end
         if (dac_sclk && !p_sclk && !dac_cs_n) begin
            chk(cnt - t_fall == ((nbits == 0) ? E_FLOW : E_BLOW), "R3 low phase",
                cnt - t_fall, (nbits == 0) ? E_FLOW : E_BLOW);
            chk(cnt - t_sdi >= DS, "R2 data setup", cnt - t_sdi, DS);
            if (nbits == 0) begin
               chk(cnt - t_csf >= CSS, "R4 select setup", cnt - t_csf, CSS);
               chk(dac_load_n && (cnt - t_ldr >= LD1), "R5 load high before first edge", cnt - t_ldr, LD1);
            end
            cap = {cap[14:0], dac_sdi};
            nbits++;
            t_rise = cnt;
         end
         if (!dac_cs_n && !dac_load_n) chk(0, "R5 load low inside frame", 0, 1);
         if (dac_cs_n && !p_cs) begin
            chk(p_sclk && dac_sclk, "R4 select rises with clock high", dac_sclk, 1);
            chk(nbits == 16, "R4 edge count", nbits, 16);
            chk(cnt - t_rise == E_LHIGH, "R4 select hold", cnt - t_rise, E_LHIGH);
         end
         if (!dac_load_n && p_ld) begin
            chk(dac_cs_n && (cnt - t_rise >= LD2), "R5 load fall delay", cnt - t_rise, LD2);
            got_frame = cap; n_frames++; t_ldf = cnt;
         end
         if (dac_load_n && !p_ld) begin
            chk(cnt - t_ldf == LDW, "R5 load width", cnt - t_ldf, LDW);
            t_ldr = cnt;
         end
         if (dac_rst_sel != p_rsel) begin
            if (!dac_rst_n) chk(0, "R6 select moved during reset", dac_rst_sel, p_rsel);
            t_sel = cnt;
         end
         if (!dac_rst_n && p_rn) begin
            chk(cnt - t_sel >= RSS, "R6 select setup", cnt - t_sel, RSS);
            chk(dac_cs_n, "R9 reset outside frame", dac_cs_n, 1);
            t_rsf = cnt;
         end
         if (dac_rst_n && !p_rn) begin
            chk(cnt - t_rsf == RSTW, "R6 reset width", cnt - t_rsf, RSTW);
            n_resets++; last_rsel = dac_rst_sel;
         end
         if (done) begin
            chk(!p_done, "R7 done single cycle", p_done, 0);
            chk((dac_load_n && !p_ld) || (dac_rst_n && !p_rn), "R7 done after pulse end", 0, 1);
         end
         if (req_ready && busy) chk(0, "R8 ready while busy", req_ready, 0);
         if (dac_cs_n && !dac_sclk) chk(0, "R10 clock idle high", dac_sclk, 1);
      end
      p_cs = dac_cs_n; p_sclk = dac_sclk; p_sdi = dac_sdi; p_ld = dac_load_n;
      p_rn = dac_rst_n; p_rsel = dac_rst_sel; p_done = done;
   end

   bit timed_out = 0;
   task automatic wait_done();
      int n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      if (!done) begin timed_out = 1; chk(0, "R7 done timeout", n, 0); end
      #1;
   endtask

   task automatic send(input logic [1:0] ch, input logic [11:0] code);
      @(negedge clk);
      req_valid = 1'b1; req_chan = ch; req_code = code;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic pulse_rst(input logic sel);
      @(negedge clk);
      rst_cmd = 1'b1; rst_sel_in = sel;
      @(negedge clk);
      rst_cmd = 1'b0;
   endtask

   initial begin
      #200000;
      timed_out = 1;
      chk(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int nf, nr;
      logic [11:0] codes [16];
      codes[0] = 12'h000; codes[1] = 12'hFFF; codes[2] = 12'h800; codes[3] = 12'h7FF;
      for (int k = 0; k < 12; k++) codes[4+k] = 12'(1 << k);

      repeat (4) @(negedge clk);
      // R10 reset state
      chk(dac_cs_n && dac_sclk && dac_load_n && dac_rst_n, "R10 pins at reset", 0, 1);
      chk(!busy && !done && !dac_rst_sel, "R10 status at reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R10 ready after reset", req_ready, 1);
      mon_on = 1;

      // R1 sweep over every channel and a spread of codes
      for (int ch = 0; ch < 4; ch++) begin
         for (int ci = 0; ci < 16; ci++) begin
            send(2'(ch), codes[ci]);
            wait_done();
            chk(got_frame == {2'(ch), 2'b00, codes[ci]}, "R1 frame content",
                int'(got_frame), int'({2'(ch), 2'b00, codes[ci]}));
         end
      end

      // R6 reset command from idle, both levels
      nr = n_resets;
      pulse_rst(1'b1); wait_done();
      chk(n_resets == nr + 1 && last_rsel == 1'b1, "R6 reset mid-scale", last_rsel, 1);
      pulse_rst(1'b0); wait_done();
      chk(n_resets == nr + 2 && last_rsel == 1'b0, "R6 reset zero-scale", last_rsel, 0);

      // R8 request held during a frame is ignored
      nf = n_frames;
      send(2'd2, 12'h5A5);
      req_valid = 1'b1; req_chan = 2'd1; req_code = 12'h3C3;
      repeat (40) @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      chk(got_frame == 16'h85A5, "R8 first frame intact", int'(got_frame), 16'h85A5);
      repeat (60) @(negedge clk);
      chk(n_frames == nf + 1, "R8 no extra frame", n_frames - nf, 1);

      // R9 reset command queued behind a frame
      nr = n_resets;
      send(2'd3, 12'hA5C);
      repeat (30) @(negedge clk);
      pulse_rst(1'b1);
      wait_done();
      chk(got_frame == 16'hCA5C, "R9 frame unaffected", int'(got_frame), 16'hCA5C);
      chk(n_resets == nr, "R9 reset waits for frame", n_resets - nr, 0);
      chk(!req_ready, "R9 ready low while reset pending", req_ready, 0);
      @(negedge clk);
      wait_done();
      chk(n_resets == nr + 1 && last_rsel == 1'b1, "R9 queued reset level", last_rsel, 1);

      repeat (10) @(negedge clk);
      chk(req_ready && !busy && dac_cs_n && dac_sclk, "R10 idle levels", busy, 0);
      if (!timed_out) begin
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule